// File: doc/BRIEF.md
# Nonvolatile store/recall controller

This block is the control state machine of a battery-free nonvolatile SRAM of 8192 bytes. It keeps the part either in plain SRAM mode, where reads and writes pass, or in transfer mode, where a STORE copies the SRAM into a shadow array or a RECALL copies the shadow array back. While a transfer runs, the SRAM port is disabled.

STORE requests come from three sources: a power-fail comparator, an active-low hardware-store pin, and a pulse from a software-sequence detector. RECALL requests come from power-up, which is reset, and from a software pulse. A RECALL asked for while the supply is low is held and runs once the supply is good again. A flag records whether any write has completed since the last STORE. Power-fail and pin STOREs run only when that flag is set. The shadow array is driven through three phase strobes: erase, program and restore. Each phase lasts a parameterised number of cycles.

Top module: `nvsram_xfer_ctrl`

## Requirements
- R1: Reset starts a RECALL. `nv_restore` and `busy` are high for exactly RESTORE_CYC cycles after reset is released, and then the block is idle.
- R2: `busy` is high exactly while a phase strobe is high. `port_off` is high whenever `busy`, `pwr_low` or a low `hw_store_n` is present, and low otherwise.
- R3: A STORE drives `nv_erase` for ERASE_CYC cycles and then, in the next cycle, `nv_prog` for PROG_CYC cycles, with no gap between the two.
- R4: When idle with the write flag set, `pwr_low` high starts a STORE in the next cycle. With the flag clear it starts nothing.
- R5: When idle with the write flag set, `hw_store_n` low starts a STORE. With the flag clear no STORE starts, and `port_off` stays high until the pin returns high.
- R6: A `sw_store` pulse while idle always starts a STORE, even when the write flag is clear.
- R7: The write flag is set by a `sram_wr_done` pulse while `port_off` is low and is cleared when a STORE finishes. A write pulse while `port_off` is high has no effect.
- R8: A `sw_recall` pulse while idle and with `pwr_low` low starts a RECALL of RESTORE_CYC cycles.
- R9: A `sw_recall` pulse while `pwr_low` is high is latched. No RECALL runs while `pwr_low` stays high. The RECALL starts in the cycle after `pwr_low` falls.
- R10: When a STORE request and a RECALL request reach an idle block in the same cycle, the STORE runs. An unlatched RECALL request is then dropped.
- R11: `sw_store`, `sw_recall` (with `pwr_low` low) and pin requests that arrive while `busy` is high start no later transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-up) |
| pwr_low | input | 1 | High when the supply is below the switch threshold |
| hw_store_n | input | 1 | Active-low hardware store request pin |
| sw_store | input | 1 | One-cycle STORE request from the sequence detector |
| sw_recall | input | 1 | One-cycle RECALL request from the sequence detector |
| sram_wr_done | input | 1 | One-cycle pulse for each completed SRAM write |
| busy | output | 1 | A STORE or RECALL is in progress |
| port_off | output | 1 | SRAM port disabled |
| nv_erase | output | 1 | Shadow array erase phase strobe |
| nv_prog | output | 1 | Shadow array program phase strobe |
| nv_restore | output | 1 | Shadow array restore phase strobe |

## Verification
The write flag is internal, so its state has to be shown through behaviour: a write pulse followed by a pin or power-fail request either starts an erase phase or does not. The hardest case to reach is the latched RECALL. The stimulus first dirties the array and lowers `pwr_low`, so that a STORE runs. It then pulses `sw_recall` while the supply is still low and keeps the supply low for several more cycles. Only after that does it release `pwr_low`, and it expects the restore strobe exactly one cycle later. A cycle-accurate behavioural model is compared on every clock, which also pins down each phase length and the priority of STORE over RECALL.

// File: rtl/nvsram_xfer_ctrl.sv
module nvsram_xfer_ctrl #(
  parameter int ERASE_CYC   = 16,
  parameter int PROG_CYC    = 32,
  parameter int RESTORE_CYC = 24
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_low,
  input  logic hw_store_n,
  input  logic sw_store,
  input  logic sw_recall,
  input  logic sram_wr_done,
  output logic busy,
  output logic port_off,
  output logic nv_erase,
  output logic nv_prog,
  output logic nv_restore
);
  localparam int MAXC = (ERASE_CYC > PROG_CYC) ?
                        ((ERASE_CYC > RESTORE_CYC) ? ERASE_CYC : RESTORE_CYC) :
                        ((PROG_CYC > RESTORE_CYC) ? PROG_CYC : RESTORE_CYC);
  localparam int CW = $clog2(MAXC + 1);

  typedef enum logic [1:0] {S_IDLE, S_ERASE, S_PROG, S_REST} st_t;

  st_t st;
  logic [CW-1:0] cnt;
  logic dirty, rc_pend;

  wire idle        = (st == S_IDLE);
  wire last        = (cnt == '0);
  wire want_store  = sw_store | (dirty & (pwr_low | ~hw_store_n));
  wire want_recall = ~pwr_low & (sw_recall | rc_pend);

  assign nv_erase   = (st == S_ERASE);
  assign nv_prog    = (st == S_PROG);
  assign nv_restore = (st == S_REST);
  assign busy       = ~idle;
  assign port_off   = busy | pwr_low | ~hw_store_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_REST;
      cnt     <= CW'(RESTORE_CYC - 1);
      dirty   <= 1'b0;
      rc_pend <= 1'b0;
    end else begin
      if (sw_recall && pwr_low) rc_pend <= 1'b1;
      if (sram_wr_done && !port_off) dirty <= 1'b1;
      case (st)
        S_IDLE:
          if (want_store) begin
            st  <= S_ERASE;
            cnt <= CW'(ERASE_CYC - 1);
          end else if (want_recall) begin
            st      <= S_REST;
            cnt     <= CW'(RESTORE_CYC - 1);
            rc_pend <= 1'b0;
          end
        S_ERASE:
          if (last) begin
            st  <= S_PROG;
            cnt <= CW'(PROG_CYC - 1);
          end else cnt <= cnt - 1'b1;
        S_PROG:
          if (last) begin
            st    <= S_IDLE;
            dirty <= 1'b0;
          end else cnt <= cnt - 1'b1;
        default:
          if (last) st <= S_IDLE;
          else cnt <= cnt - 1'b1;
      endcase
    end
  end

  AST_PROG_AFTER_ERASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(nv_prog) |-> $past(nv_erase)); // R3
  AST_CLEAN_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !dirty && !sw_store) |=> !nv_erase); // R5
  AST_SW_STORE_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && sw_store) |=> nv_erase); // R6
  AST_STORE_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nv_prog) |-> !dirty); // R7
  AST_LOW_NO_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && pwr_low) |=> !nv_restore); // R9
  AST_STORE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && sw_store && sw_recall) |=> (nv_erase && !nv_restore)); // R10
endmodule

// File: tb/test_nvsram_xfer_ctrl.sv
module test_nvsram_xfer_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int EC = 3, PC = 4, RC = 5;

  logic clk = 0, rst_n = 0;
  logic pwr_low = 0, hw_store_n = 1, sw_store = 0, sw_recall = 0, sram_wr_done = 0;
  logic busy, port_off, nv_erase, nv_prog, nv_restore;

  nvsram_xfer_ctrl #(.ERASE_CYC(EC), .PROG_CYC(PC), .RESTORE_CYC(RC)) i_nvsram_xfer_ctrl (
    .clk(clk), .rst_n(rst_n), .pwr_low(pwr_low), .hw_store_n(hw_store_n),
    .sw_store(sw_store), .sw_recall(sw_recall), .sram_wr_done(sram_wr_done),
    .busy(busy), .port_off(port_off), .nv_erase(nv_erase), .nv_prog(nv_prog),
    .nv_restore(nv_restore));

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 0;

  // reference model: 0 idle, 1 erase, 2 program, 3 restore
  int ph = 3, left = RC;
  bit mdirty = 0, mpend = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 3; left = RC; mdirty = 0; mpend = 0;
    end else begin
      bit off_now, d_old;
      off_now = (ph != 0) || pwr_low || !hw_store_n;
      d_old = mdirty;
      if (sw_recall && pwr_low) mpend = 1;
      if (sram_wr_done && !off_now) mdirty = 1;
      if (ph == 0) begin
        if (sw_store || (d_old && (pwr_low || !hw_store_n))) begin ph = 1; left = EC; end
        else if (!pwr_low && (sw_recall || mpend)) begin ph = 3; left = RC; mpend = 0; end
      end else begin
        left--;
        if (left == 0) begin
          if (ph == 1) begin ph = 2; left = PC; end
          else begin
            if (ph == 2) mdirty = 0;
            ph = 0;
          end
        end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // run-length and sighting monitor, plus per-cycle comparison
  int run_e = 0, run_p = 0, run_r = 0, len_e = 0, len_p = 0, len_r = 0;
  bit seen_e = 0, seen_r = 0;
  always @(negedge clk) if (rst_n && !done) begin
    chk(busy == (ph != 0), "R2 busy", busy, ph != 0);
    chk(port_off == ((ph != 0) || pwr_low || !hw_store_n), "R2 port_off", port_off,
        (ph != 0) || pwr_low || !hw_store_n);
    chk(nv_erase == (ph == 1), "R3 nv_erase", nv_erase, ph == 1);
    chk(nv_prog == (ph == 2), "R3 nv_prog", nv_prog, ph == 2);
    chk(nv_restore == (ph == 3), "R8 nv_restore", nv_restore, ph == 3);
    if (nv_erase) begin run_e++; seen_e = 1; end else if (run_e) begin len_e = run_e; run_e = 0; end
    if (nv_prog) run_p++; else if (run_p) begin len_p = run_p; run_p = 0; end
    if (nv_restore) begin run_r++; seen_r = 1; end else if (run_r) begin len_r = run_r; run_r = 0; end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 100 && busy; k++) step(1);
    step(1);
  endtask

  task automatic clear_seen();
    seen_e = 0; seen_r = 0; len_e = 0; len_p = 0; len_r = 0;
  endtask

  task automatic write_pulse();
    sram_wr_done = 1; step(1); sram_wr_done = 0;
  endtask

  initial begin
    step(2);
    rst_n = 1;
    #1;
    chk(busy && nv_restore, "R1 reset recall", busy, 1);
    wait_idle();
    chk(len_r == RC, "R1 recall length", len_r, RC);

    clear_seen();
    sw_store = 1; step(1); sw_store = 0;
    wait_idle();
    chk(len_e == EC, "R3 erase length", len_e, EC);
    chk(len_p == PC, "R6 clean sw store ran", len_p, PC);

    clear_seen();
    hw_store_n = 0; step(6);
    chk(port_off, "R5 pin low holds port off", port_off, 1);
    hw_store_n = 1; step(1);
    chk(!seen_e, "R5 clean pin store ignored", seen_e, 0);
    chk(!port_off, "R5 port back on", port_off, 0);

    clear_seen();
    hw_store_n = 0; step(1);
    write_pulse();
    hw_store_n = 1; step(2);
    hw_store_n = 0; step(3); hw_store_n = 1; step(2);
    chk(!seen_e, "R7 blocked write ignored", seen_e, 0);

    clear_seen();
    write_pulse();
    hw_store_n = 0; step(2); hw_store_n = 1;
    wait_idle();
    chk(seen_e && len_p == PC, "R5 dirty pin store", seen_e, 1);
    clear_seen();
    hw_store_n = 0; step(3); hw_store_n = 1; step(2);
    chk(!seen_e, "R7 flag cleared by store", seen_e, 0);

    clear_seen();
    write_pulse();
    pwr_low = 1; step(1);
    wait_idle();
    chk(seen_e, "R4 power fail store", seen_e, 1);
    sw_recall = 1; step(1); sw_recall = 0;
    step(5);
    chk(!seen_r, "R9 no recall while low", seen_r, 0);
    pwr_low = 0; step(1);
    chk(nv_restore, "R9 latched recall starts", nv_restore, 1);
    wait_idle();
    chk(len_r == RC, "R9 recall length", len_r, RC);

    clear_seen();
    pwr_low = 1; step(4); pwr_low = 0; step(2);
    chk(!seen_e && !seen_r, "R4 clean power fail ignored", seen_e, 0);

    clear_seen();
    sw_store = 1; sw_recall = 1; step(1); sw_store = 0; sw_recall = 0;
    chk(nv_erase, "R10 store wins", nv_erase, 1);
    wait_idle(); step(3);
    chk(!seen_r, "R10 recall dropped", seen_r, 0);

    clear_seen();
    sw_store = 1; step(1); sw_store = 0; step(1);
    sw_recall = 1; step(1); sw_recall = 0;
    sw_store = 1; step(1); sw_store = 0;
    write_pulse();
    wait_idle(); step(3);
    chk(!seen_r && len_p == PC, "R11 requests while busy ignored", seen_r, 0);
    hw_store_n = 0; step(3); hw_store_n = 1; step(2);
    chk(len_p == PC && !nv_erase, "R11 busy write ignored", nv_erase, 0);

    clear_seen();
    sw_recall = 1; step(1); sw_recall = 0;
    wait_idle();
    chk(len_r == RC && !seen_e, "R8 sw recall length", len_r, RC);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule